// File: doc/BRIEF.md
# Serializer/Deserializer Mode and Clock-Source Controller

This controller turns a two-pin mode code and a direction pin into the enables that run one end of a bidirectional 24-bit serial link. Code 00 is the power-down state. In power-down the block drives a global reset and a high-impedance request for the pads, and it keeps the PLL and the input receivers off. Each of the three non-zero codes selects a reference-clock frequency band, and the direction pin then chooses between serializing and deserializing.

The block also decides where the serializer takes its bit clock from. After power-up it uses an external free-running bit clock. When a filter in the sampling clock domain sees steady activity on the reference-clock input, the block switches to reference-clock serialization. That choice is a one-way latch. Only a pass through power-down whose exit happens while the reference input is low returns the block to the external bit clock.

When the serializer runs from the reference clock, its data-valid enable waits until the PLL has reported lock for a qualified number of reference edges.

Top module: `serdes_mode_ctrl`

## Requirements
- R1: When {sel_hi_i,sel_lo_i} = 00, the following hold in the same cycle: pwr_down_o, glob_rst_o and hiz_req_o are 1; rx_en_o, pll_en_o, ser_en_o, des_en_o, ser_data_en_o and wclk_hold_hi_o are 0; range_o is 0.
- R2: In operating modes, range_o equals {sel_hi_i,sel_lo_i}. Code 1 is the 2–5 MHz band, code 2 the 5–15 MHz band and code 3 the 10–30 MHz band. rx_en_o is 1 in operating modes.
- R3: In an operating mode, dir_ser_i = 1 gives ser_en_o = 1, des_en_o = 0 and wclk_hold_hi_o = 1. dir_ser_i = 0 gives ser_en_o = 0, des_en_o = 1 and wclk_hold_hi_o = 0.
- R4: After reset, clk_from_ref_o is 0, which means the serializer uses the external bit clock.
- R5: A rising edge is a sample of ref_clk_i at 1 whose previous sample was 0, taken outside power-down. On the clock after the sample that holds the EDGE_COUNT-th (4) rising edge, clk_from_ref_o becomes 1. If GAP_LIMIT (8) consecutive samples pass without a rising edge, the edge count restarts.
- R6: Once clk_from_ref_o is 1, stopping the reference input does not clear it, and neither does changing mode or direction.
- R7: clk_from_ref_o returns to 0 only on the clock after the first operating-mode sample that follows power-down, and only if ref_clk_i is 0 in that sample. If ref_clk_i is 1 at that exit, clk_from_ref_o stays 1.
- R8: pll_en_o is 1 only in an operating mode after reference activity has been detected, as in R5, since the last power-down. Power-down clears that detection, and reference edges seen during power-down are ignored.
- R9: ser_data_en_o = ser_en_o AND (clk_from_ref_o = 0 OR pll_lock_i has been 1 for LOCK_EDGES (16) reference rising edges). A low pll_lock_i or power-down restarts that count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sampling clock |
| rst_n | input | 1 | Active-low power-on reset |
| sel_lo_i | input | 1 | Mode code, low bit |
| sel_hi_i | input | 1 | Mode code, high bit |
| dir_ser_i | input | 1 | 1 selects serializer, 0 selects deserializer |
| ref_clk_i | input | 1 | Reference clock level, sampled |
| pll_lock_i | input | 1 | PLL lock flag |
| pwr_down_o | output | 1 | Power-down state |
| glob_rst_o | output | 1 | Global reset to the link logic |
| hiz_req_o | output | 1 | Request to float all outputs |
| rx_en_o | output | 1 | Input receiver enable |
| pll_en_o | output | 1 | PLL enable |
| ser_en_o | output | 1 | Serializer enable |
| des_en_o | output | 1 | Deserializer enable |
| ser_data_en_o | output | 1 | Serializer data-valid enable |
| range_o | output | 2 | Reference frequency band code |
| clk_from_ref_o | output | 1 | 1: serialize from reference clock, 0: from external bit clock |
| wclk_hold_hi_o | output | 1 | Forces the parallel word clock high |

## Verification
The bench builds the block with its default parameters: four edges for detection, an eight-sample gap limit and sixteen lock edges. With a reference that toggles every two samples, these values bring a gap that breaks the edge count, full lock qualification and a loss of lock within a short run. Both ways out of power-down are covered, with the reference held high and with it held low. Edges that arrive during power-down are also driven, so the run shows that they are ignored.

// File: rtl/smc_pkg.sv
package smc_pkg;
    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_BAND1 = 2'd1,
        MODE_BAND2 = 2'd2,
        MODE_BAND3 = 2'd3
    } mode_e;

    typedef struct packed {
        logic pd;
        logic ser;
        logic des;
    } path_t;
endpackage

// File: rtl/smc_mode_dec.sv
module smc_mode_dec
    import smc_pkg::*;
(
    input  logic  sel_lo,
    input  logic  sel_hi,
    input  logic  dir_ser,
    output mode_e mode,
    output path_t path
);
    always_comb begin
        mode     = mode_e'({sel_hi, sel_lo});
        path.pd  = (mode == MODE_OFF);
        path.ser = !path.pd && dir_ser;
        path.des = !path.pd && !dir_ser;
    end
endmodule

// File: rtl/smc_ref_det.sv
module smc_ref_det #(
    parameter int EDGE_COUNT = 4,
    parameter int GAP_LIMIT  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd,
    input  logic ref_in,
    output logic edge_o,
    output logic valid_o,
    output logic sel_o
);
    localparam int CW = $clog2(EDGE_COUNT + 1);
    localparam int GW = $clog2(GAP_LIMIT + 1);

    typedef struct packed {
        logic          prev;
        logic          pd_prev;
        logic [GW-1:0] gap;
        logic [CW-1:0] cnt;
        logic          valid;
        logic          sel;
    } det_t;

    det_t det_d, det_q;
    logic edge_w;

    always_comb begin
        det_d         = det_q;
        det_d.prev    = ref_in;
        det_d.pd_prev = pd;
        edge_w        = ref_in && !det_q.prev && !pd;
        if (pd) begin
            det_d.gap   = '0;
            det_d.cnt   = '0;
            det_d.valid = 1'b0;
        end else begin
            if (det_q.pd_prev && !ref_in)
                det_d.sel = 1'b0;
            if (edge_w) begin
                det_d.gap = '0;
                if (det_q.cnt < CW'(EDGE_COUNT))
                    det_d.cnt = det_q.cnt + 1'b1;
                if (det_q.cnt >= CW'(EDGE_COUNT - 1)) begin
                    det_d.valid = 1'b1;
                    det_d.sel   = 1'b1;
                end
            end else begin
                if (det_q.gap == GW'(GAP_LIMIT - 1))
                    det_d.cnt = '0;
                if (det_q.gap < GW'(GAP_LIMIT))
                    det_d.gap = det_q.gap + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end

    assign edge_o  = edge_w;
    assign valid_o = det_q.valid;
    assign sel_o   = det_q.sel;

    // R6: the source latch holds unless a power-down exit occurs
    a_r6_sel_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (det_q.sel && !pd && !det_q.pd_prev) |=> det_q.sel);
    // R5: the latch only rises right after a sampled reference edge
    a_r5_rise_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(det_q.sel) |-> $past(edge_w));
    // R8: power-down drops activity detection
    a_r8_pd_clears_valid: assert property (@(posedge clk) disable iff (!rst_n)
        pd |=> !det_q.valid);
endmodule

// File: rtl/smc_lock_qual.sv
module smc_lock_qual #(
    parameter int LOCK_EDGES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd,
    input  logic ref_edge,
    input  logic locked,
    output logic ok_o
);
    localparam int LW = $clog2(LOCK_EDGES + 1);

    typedef struct packed {
        logic [LW-1:0] cnt;
    } lk_t;

    lk_t lk_d, lk_q;

    always_comb begin
        lk_d = lk_q;
        if (pd || !locked)
            lk_d.cnt = '0;
        else if (ref_edge && lk_q.cnt < LW'(LOCK_EDGES))
            lk_d.cnt = lk_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= '0;
        else        lk_q <= lk_d;
    end

    assign ok_o = (lk_q.cnt == LW'(LOCK_EDGES));

    // R9: losing lock removes qualification on the next clock
    a_r9_unlock_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |=> !ok_o);
endmodule

// File: rtl/serdes_mode_ctrl.sv
module serdes_mode_ctrl
    import smc_pkg::*;
#(
    parameter int EDGE_COUNT = 4,
    parameter int GAP_LIMIT  = 8,
    parameter int LOCK_EDGES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_lo_i,
    input  logic       sel_hi_i,
    input  logic       dir_ser_i,
    input  logic       ref_clk_i,
    input  logic       pll_lock_i,
    output logic       pwr_down_o,
    output logic       glob_rst_o,
    output logic       hiz_req_o,
    output logic       rx_en_o,
    output logic       pll_en_o,
    output logic       ser_en_o,
    output logic       des_en_o,
    output logic       ser_data_en_o,
    output logic [1:0] range_o,
    output logic       clk_from_ref_o,
    output logic       wclk_hold_hi_o
);
    mode_e mode;
    path_t path;
    logic  ref_edge, ref_valid, src_ref, lock_ok;

    smc_mode_dec i_dec (
        .sel_lo (sel_lo_i),
        .sel_hi (sel_hi_i),
        .dir_ser(dir_ser_i),
        .mode   (mode),
        .path   (path)
    );

    smc_ref_det #(.EDGE_COUNT(EDGE_COUNT), .GAP_LIMIT(GAP_LIMIT)) i_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .pd     (path.pd),
        .ref_in (ref_clk_i),
        .edge_o (ref_edge),
        .valid_o(ref_valid),
        .sel_o  (src_ref)
    );

    smc_lock_qual #(.LOCK_EDGES(LOCK_EDGES)) i_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .pd      (path.pd),
        .ref_edge(ref_edge),
        .locked  (pll_lock_i),
        .ok_o    (lock_ok)
    );

    always_comb begin
        pwr_down_o     = path.pd;
        glob_rst_o     = path.pd;
        hiz_req_o      = path.pd;
        rx_en_o        = !path.pd;
        pll_en_o       = !path.pd && ref_valid;
        ser_en_o       = path.ser;
        des_en_o       = path.des;
        wclk_hold_hi_o = path.ser;
        range_o        = path.pd ? 2'd0 : 2'(mode);
        clk_from_ref_o = src_ref;
        ser_data_en_o  = path.ser && (!src_ref || lock_ok);
    end

    // R1: power-down floats the pads and stops both paths
    a_r1_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        hiz_req_o |-> (!ser_en_o && !des_en_o && !pll_en_o));
    // R3: the two directions never run together
    a_r3_one_path: assert property (@(posedge clk) disable iff (!rst_n)
        !(ser_en_o && des_en_o));
    // R9: data-valid implies the serializer is selected
    a_r9_data_needs_ser: assert property (@(posedge clk) disable iff (!rst_n)
        ser_data_en_o |-> ser_en_o);
endmodule

// File: tb/test_serdes_mode_ctrl.sv
module test_serdes_mode_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int EC = 4, GL = 8, LE = 16;

    logic clk = 0, rst_n = 0;
    logic s_lo = 0, s_hi = 0, dir = 0, refc = 0, lock = 0;
    logic pwr_down, glob_rst, hiz, rx_en, pll_en, ser_en, des_en, ser_data_en;
    logic [1:0] range_v;
    logic from_ref, wclk_hi;

    int checks = 0, fails = 0;

    serdes_mode_ctrl #(.EDGE_COUNT(EC), .GAP_LIMIT(GL), .LOCK_EDGES(LE)) i_serdes_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .sel_lo_i(s_lo), .sel_hi_i(s_hi),
        .dir_ser_i(dir), .ref_clk_i(refc), .pll_lock_i(lock),
        .pwr_down_o(pwr_down), .glob_rst_o(glob_rst), .hiz_req_o(hiz),
        .rx_en_o(rx_en), .pll_en_o(pll_en), .ser_en_o(ser_en), .des_en_o(des_en),
        .ser_data_en_o(ser_data_en), .range_o(range_v),
        .clk_from_ref_o(from_ref), .wclk_hold_hi_o(wclk_hi)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    bit m_prev, m_pdprev, m_valid, m_sel;
    int m_gap, m_cnt, m_lock;

    always @(posedge clk) begin
        bit pd, edg;
        pd  = ({s_hi, s_lo} == 2'b00);
        edg = refc && !m_prev && !pd;
        if (!rst_n) begin
            m_prev = 0; m_pdprev = 0; m_valid = 0; m_sel = 0;
            m_gap = 0; m_cnt = 0; m_lock = 0;
        end else begin
            if (pd || !lock) m_lock = 0;
            else if (edg && m_lock < LE) m_lock++;
            if (pd) begin
                m_gap = 0; m_cnt = 0; m_valid = 0;
            end else begin
                if (m_pdprev && !refc) m_sel = 0;
                if (edg) begin
                    m_gap = 0;
                    if (m_cnt < EC) m_cnt++;
                    if (m_cnt >= EC) begin m_valid = 1; m_sel = 1; end
                end else begin
                    if (m_gap == GL - 1) m_cnt = 0;
                    if (m_gap < GL) m_gap++;
                end
            end
            m_prev = refc; m_pdprev = pd;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    task automatic compare();
        bit pd, es, ed;
        pd = ({s_hi, s_lo} == 2'b00);
        es = !pd && dir; ed = !pd && !dir;
        chk(pwr_down == pd && glob_rst == pd && hiz == pd, "R1 pd/reset/hiz",
            {pwr_down, glob_rst, hiz}, {pd, pd, pd});
        chk(rx_en == !pd, "R2 rx_en", rx_en, !pd);
        chk(range_v == (pd ? 2'd0 : {s_hi, s_lo}), "R2 range", range_v, pd ? 0 : {s_hi, s_lo});
        chk(ser_en == es && des_en == ed && wclk_hi == es, "R3 path",
            {ser_en, des_en, wclk_hi}, {es, ed, es});
        chk(from_ref == m_sel, "R5 R6 R7 clk source", from_ref, m_sel);
        chk(pll_en == (!pd && m_valid), "R8 pll_en", pll_en, !pd && m_valid);
        chk(ser_data_en == (es && (!m_sel || m_lock == LE)), "R9 data enable",
            ser_data_en, es && (!m_sel || m_lock == LE));
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rst_n) compare();
        end
    endtask

    task automatic set_mode(input logic [1:0] m, input logic d);
        @(negedge clk);
        if (rst_n) compare();
        {s_hi, s_lo} = m; dir = d;
    endtask

    task automatic pulses(input int n, input int half);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); compare(); refc = 1;
            step(half - 1);
            @(negedge clk); compare(); refc = 0;
            step(half - 1);
        end
    endtask

    initial begin
        int wd = 0;
        while (wd < 50000) begin @(posedge clk); wd++; end
        fails++;
        $display("FAIL watchdog: actual %0d expected 0", wd);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 R4 reset state with mode 00
        chk(hiz && glob_rst && !ser_en && !des_en && range_v == 0, "R1 reset pd", hiz, 1);
        chk(from_ref == 0, "R4 reset source", from_ref, 0);
        rst_n = 1;
        step(3);
        set_mode(2'b01, 1); step(4);
        chk(ser_data_en == 1 && from_ref == 0, "R4 ext clock data", ser_data_en, 1);
        set_mode(2'b10, 0); step(3);
        chk(des_en == 1 && wclk_hi == 0 && range_v == 2, "R3 deser", des_en, 1);
        set_mode(2'b11, 1); step(3);
        chk(range_v == 3 && wclk_hi == 1, "R2 band3", range_v, 3);
        // R5: three edges, then a long gap restarts the count
        pulses(3, 2);
        step(12);
        chk(from_ref == 0, "R5 gap restart", from_ref, 0);
        lock = 1;
        pulses(4, 2);
        step(1);
        chk(from_ref == 1 && pll_en == 1, "R5 detect", from_ref, 1);
        pulses(LE + 2, 2);
        chk(ser_data_en == 1, "R9 lock qualified", ser_data_en, 1);
        lock = 0; step(2);
        chk(ser_data_en == 0, "R9 lock lost", ser_data_en, 0);
        lock = 1; pulses(5, 2);
        chk(ser_data_en == 0, "R9 requalify pending", ser_data_en, 0);
        // R6: reference stops, mode changes
        step(20); set_mode(2'b01, 0); step(5);
        chk(from_ref == 1, "R6 sticky", from_ref, 1);
        // R7: exit power-down with reference high keeps source
        set_mode(2'b00, 0); step(3);
        @(negedge clk); compare(); refc = 1;
        set_mode(2'b10, 1); step(3);
        chk(from_ref == 1 && pll_en == 0, "R7 exit high keeps", from_ref, 1);
        // R8: edges during power-down ignored
        set_mode(2'b00, 1);
        refc = 0;
        pulses(6, 2);
        chk(pll_en == 0, "R8 pd edges ignored", pll_en, 0);
        // R7: exit with reference low clears source
        set_mode(2'b11, 1); step(3);
        chk(from_ref == 0, "R7 exit low clears", from_ref, 0);
        pulses(5, 3);
        step(2);
        chk(from_ref == 1 && pll_en == 1, "R5 R8 redetect", from_ref, 1);
        step(4);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule